// File: doc/BRIEF.md
# Masked pattern match trigger unit

The unit watches a wide sampled data word. On each sample it checks the word against two value/mask pairs that are programmed separately. The capture pair decides whether the sample is one to keep, and `cap_match_o` flags it. The trigger pair raises a trigger pulse. There are two trigger styles: a pulse on every matching sample, or a pulse only on the first sample of a run of matches.

Either comparison can also ask an external timestamp counter for a timestamp. A capture-pair match requests one when pattern timestamps are enabled. The type bit selects whether that happens on every matching sample or only when the match state changes. A trigger pulse requests one when trigger timestamps are enabled. The timestamp counter and the data transport lie outside this block.

All outputs are registered and appear one clock after the sample they describe. Samples count only while `en_i` and `sample_valid_i` are both high.

Top module: `pat_trig_unit`

## Requirements
- R1: A sample counts when `en_i` and `sample_valid_i` are both high. For such a sample, the capture pair matches when `((data_i ^ cap_val_i) & cap_mask_i) == 0`, where a mask bit of 1 means that bit is compared. `cap_match_o` shows the result one clock after the sample.
- R2: The trigger pair (`trg_val_i`, `trg_mask_i`) uses the same compare rule on its own registers. With `trg_edge_i` = 0, `trig_o` pulses one clock after every counted sample whose trigger compare matches.
- R3: With `trg_edge_i` = 1, `trig_o` pulses only when the trigger compare matches and the previous counted sample did not match. Samples that are not counted leave this history unchanged.
- R4: When `en_i` or `sample_valid_i` is low, all outputs are 0 in the following cycle. While `en_i` is low, both match histories are cleared to "no match".
- R5: When `pts_en_i` = 0, capture matches request no timestamp, and `pts_type_i` has no effect on any output.
- R6: With `pts_en_i` = 1 and `pts_type_i` = 0, every counted sample that matches the capture pair sets `ts_req_o` one clock later.
- R7: With `pts_en_i` = 1 and `pts_type_i` = 1, `ts_req_o` is set only for a counted sample whose capture result differs from that of the previous counted sample. A change in either direction counts. `ts_type_o` is 1 exactly when the request comes from a pattern request of this type; otherwise it is 0.
- R8: When `tts_en_i` = 1, every `trig_o` pulse also sets `ts_req_o` in the same cycle. When `tts_en_i` = 0, trigger pulses request nothing.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Unit enable |
| sample_valid_i | input | 1 | Sample strobe |
| data_i | input | DATA_W | Sampled data word |
| cap_val_i | input | DATA_W | Capture pattern value |
| cap_mask_i | input | DATA_W | Capture pattern mask (1 = compare) |
| trg_val_i | input | DATA_W | Trigger pattern value |
| trg_mask_i | input | DATA_W | Trigger pattern mask (1 = compare) |
| trg_edge_i | input | 1 | Trigger type: 0 every match, 1 first of a run |
| pts_en_i | input | 1 | Pattern timestamp enable |
| pts_type_i | input | 1 | Pattern timestamp type: 0 every match, 1 on change |
| tts_en_i | input | 1 | Trigger timestamp enable |
| cap_match_o | output | 1 | Capture pattern matched |
| trig_o | output | 1 | Trigger pulse |
| ts_req_o | output | 1 | Timestamp request pulse |
| ts_type_o | output | 1 | Request is a change-type pattern request |

## Verification
Most samples are built as either capture value or trigger value, with random changes confined to unmasked bits. Holding the previous word produces runs of matches, which separate edge-mode triggering from level mode and on-change timestamps from every-match timestamps. Fully random words give mismatches and match-to-no-match transitions, so a falling change is seen to request a timestamp. Directed cases help locate specific faults:
- An all-zero mask must always match, which exposes an inverted mask sense.
- A full mask with a single flipped bit must fail, which exposes a reduced compare.
- Matching data presented with the unit disabled or the strobe low must leave every output quiet.

// File: rtl/pat_trig_pkg.sv
package pat_trig_pkg;
  typedef enum logic {TRG_LEVEL = 1'b0, TRG_FIRST = 1'b1} trg_mode_e;
  typedef enum logic {TS_EVERY = 1'b0, TS_CHANGE = 1'b1} ts_mode_e;
endpackage

// File: rtl/pat_cmp.sv
module pat_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  assign hit_o = ~|((data_i ^ val_i) & mask_i);
endmodule

// File: rtl/match_track.sv
module match_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic hit_i,
  output logic prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_o <= 1'b0;
    else if (clr_i)  prev_o <= 1'b0;
    else if (step_i) prev_o <= hit_i;
  end
endmodule

// File: rtl/pat_trig_unit.sv
module pat_trig_unit
  import pat_trig_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cap_val_i,
  input  logic [DATA_W-1:0] cap_mask_i,
  input  logic [DATA_W-1:0] trg_val_i,
  input  logic [DATA_W-1:0] trg_mask_i,
  input  logic              trg_edge_i,
  input  logic              pts_en_i,
  input  logic              pts_type_i,
  input  logic              tts_en_i,
  output logic              cap_match_o,
  output logic              trig_o,
  output logic              ts_req_o,
  output logic              ts_type_o
);
  localparam int NCH = 2;  // 0 capture, 1 trigger

  logic [NCH-1:0][DATA_W-1:0] vals, masks;
  logic [NCH-1:0] hit, prev;
  logic step;
  trg_mode_e trg_mode;
  ts_mode_e  ts_mode;

  assign vals  = {trg_val_i, cap_val_i};
  assign masks = {trg_mask_i, cap_mask_i};
  assign step  = en_i & sample_valid_i;
  assign trg_mode = trg_mode_e'(trg_edge_i);
  assign ts_mode  = ts_mode_e'(pts_type_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pat_cmp #(.W(DATA_W)) u_cmp (
      .data_i(data_i), .val_i(vals[c]), .mask_i(masks[c]), .hit_o(hit[c])
    );
    match_track u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(~en_i), .step_i(step),
      .hit_i(hit[c]), .prev_o(prev[c])
    );
  end

  logic trg_fire, pts_fire, tts_fire;
  always_comb begin
    trg_fire = step & hit[1] & ((trg_mode == TRG_LEVEL) | ~prev[1]);
    pts_fire = step & pts_en_i &
               ((ts_mode == TS_CHANGE) ? (hit[0] ^ prev[0]) : hit[0]);
    tts_fire = trg_fire & tts_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_match_o <= 1'b0;
      trig_o      <= 1'b0;
      ts_req_o    <= 1'b0;
      ts_type_o   <= 1'b0;
    end else begin
      cap_match_o <= step & hit[0];
      trig_o      <= trg_fire;
      ts_req_o    <= pts_fire | tts_fire;
      ts_type_o   <= pts_fire & (ts_mode == TS_CHANGE);
    end
  end
endmodule

// File: rtl/pat_trig_unit_chk.sv
module pat_trig_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sample_valid_i,
  input logic trg_edge_i,
  input logic pts_en_i,
  input logic pts_type_i,
  input logic tts_en_i,
  input logic cap_match_o,
  input logic trig_o,
  input logic ts_req_o,
  input logic ts_type_o
);
  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && sample_valid_i) |=> (!cap_match_o && !trig_o && !ts_req_o));

  assert_first_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && en_i && sample_valid_i && trg_edge_i) |=> !trig_o);

  assert_no_ts_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pts_en_i && !tts_en_i) |=> !ts_req_o);

  assert_every_match_ts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_valid_i && pts_en_i && !pts_type_i && !tts_en_i)
      |=> (ts_req_o == cap_match_o));

  assert_type_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_type_o |-> ts_req_o);

  assert_trig_ts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_valid_i && tts_en_i) |=> (!trig_o || ts_req_o));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!cap_match_o && !trig_o && !ts_req_o && !ts_type_o);
    end
  end
endmodule

bind pat_trig_unit pat_trig_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_valid_i(sample_valid_i),
  .trg_edge_i(trg_edge_i), .pts_en_i(pts_en_i), .pts_type_i(pts_type_i),
  .tts_en_i(tts_en_i), .cap_match_o(cap_match_o), .trig_o(trig_o),
  .ts_req_o(ts_req_o), .ts_type_o(ts_type_o)
);

// File: tb/pat_trig_unit_test.sv
module pat_trig_unit_test;
  localparam int W = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en, valid, trg_edge, pts_en, pts_type, tts_en;
  logic [W-1:0] data, cap_val, cap_mask, trg_val, trg_mask;
  logic cap_match, trig, ts_req, ts_type;

  pat_trig_unit #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sample_valid_i(valid),
    .data_i(data), .cap_val_i(cap_val), .cap_mask_i(cap_mask),
    .trg_val_i(trg_val), .trg_mask_i(trg_mask), .trg_edge_i(trg_edge),
    .pts_en_i(pts_en), .pts_type_i(pts_type), .tts_en_i(tts_en),
    .cap_match_o(cap_match), .trig_o(trig), .ts_req_o(ts_req), .ts_type_o(ts_type)
  );

  int errors = 0, checks = 0;
  logic m_cap_prev = 1'b0, m_trg_prev = 1'b0;
  logic e_cap, e_trig, e_req, e_type;
  string l_cap, l_trig, l_ts;

  function automatic logic hit(logic [W-1:0] d, logic [W-1:0] v, logic [W-1:0] m);
    return ((d ^ v) & m) == '0;
  endfunction

  function automatic logic [W-1:0] r64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Predict outputs for the stimulus now on the inputs, advance model history.
  task automatic predict();
    logic s, ch, th, tf, pf;
    s  = en & valid;
    ch = hit(data, cap_val, cap_mask);
    th = hit(data, trg_val, trg_mask);
    tf = s & th & (!trg_edge | !m_trg_prev);
    pf = s & pts_en & (pts_type ? (ch != m_cap_prev) : ch);
    e_cap = s & ch; e_trig = tf; e_req = pf | (tf & tts_en); e_type = pf & pts_type;
    l_cap  = s ? "R1" : "R4";
    l_trig = !s ? "R4" : (trg_edge ? "R3" : "R2");
    l_ts   = !s ? "R4" : (!pts_en ? (tts_en ? "R8" : "R5") : (pts_type ? "R7" : "R6"));
    if (!en) begin m_cap_prev = 1'b0; m_trg_prev = 1'b0; end
    else if (s) begin m_cap_prev = ch; m_trg_prev = th; end
  endtask

  task automatic tick();
    predict();
    @(negedge clk);
    check(l_cap, "cap_match_o", cap_match, e_cap);
    check(l_trig, "trig_o", trig, e_trig);
    check(l_ts, "ts_req_o", ts_req, e_req);
    check(l_ts, "ts_type_o", ts_type, e_type);
  endtask

  task automatic rand_sample();
    int unsigned r;
    r = $urandom % 5;
    valid = ($urandom % 8) != 0;
    en    = ($urandom % 40) != 0;
    case (r)
      0: data = cap_val ^ (~cap_mask & r64());
      1: data = trg_val ^ (~trg_mask & r64());
      2: data = r64();
      default: ;  // hold word to build runs
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; en = 1'b0; valid = 1'b0;
    trg_edge = 1'b0; pts_en = 1'b0; pts_type = 1'b0; tts_en = 1'b0;
    data = '0; cap_val = '0; cap_mask = '0; trg_val = '0; trg_mask = '0;
    repeat (2) @(negedge clk);
    // R9: reset state with inputs that would otherwise fire
    en = 1'b1; valid = 1'b1; pts_en = 1'b1; tts_en = 1'b1;
    @(negedge clk);
    check("R9", "cap_match_o", cap_match, 1'b0);
    check("R9", "trig_o", trig, 1'b0);
    check("R9", "ts_req_o", ts_req, 1'b0);
    check("R9", "ts_type_o", ts_type, 1'b0);
    en = 1'b0; valid = 1'b0;
    rst_n = 1'b1;
    tick();

    // Directed R1: zero mask always matches
    cap_val = r64(); cap_mask = '0; trg_val = r64(); trg_mask = '1;
    data = r64(); en = 1'b1; valid = 1'b1;
    tick(); tick();
    // Directed R1: full mask, one differing bit -> no match
    cap_mask = '1; data = cap_val ^ (64'd1 << 37);
    tick();
    data = cap_val; tick();
    // Directed R3: run of trigger matches with a gap in the strobe
    trg_edge = 1'b1; data = trg_val;
    tick(); tick(); valid = 1'b0; tick(); valid = 1'b1; tick();
    // Directed R4: matching data while disabled, history cleared
    en = 1'b0; tick(); en = 1'b1; tick();
    // Directed R5: type bit has no effect with pattern timestamps off
    pts_en = 1'b0; tts_en = 1'b0; pts_type = 1'b1; data = cap_val;
    tick(); data = r64(); tick();

    for (int cfg = 0; cfg < 16; cfg++) begin
      trg_edge = cfg[0]; pts_en = cfg[1]; pts_type = cfg[2]; tts_en = cfg[3];
      cap_val = r64(); trg_val = r64();
      cap_mask = r64() & r64(); trg_mask = r64() & r64();
      for (int n = 0; n < 400; n++) begin
        rand_sample();
        tick();
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule